// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block is the control slice of a 64-bit processor's exception path. The processor has four privilege levels, 0 to 3. The block takes in three kinds of request. The first is synchronous faults and calls: instruction abort, data abort, supervisor call, hypervisor call and secure-monitor call. The second is asynchronous SError, FIQ and IRQ requests. The third is an exception-return strobe. In each cycle it accepts at most one event. For an accepted event it chooses the level that takes the event and forms the handler address. It saves or restores the processor state, and it drives the next program counter.

A pipeline front end presents the request lines together with the address of the instruction that would resume after the event. Handler code writes the saved-state and link registers of the level it runs at through a save-write port. This lets a later return drop to a chosen lower level and execution width.

The control is a two-state machine. `ST_BOOT` is held while `rst_n` is low. On the first clock edge after reset is released it takes the transition *boot-fetch* into `ST_RUN`. `ST_RUN` stays in `ST_RUN` on each of its three transitions:
- *entry*: a fault, call or interrupt is taken.
- *return*: an exception return, legal or illegal.
- *idle*: no event is accepted.

Top module: `exc_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and `ev_o` is 0. On the first edge after release, reset is accepted whatever other requests are present: `pc_o` becomes `rst_base_i`, `pstate_o` becomes 0x1E7 (level 3, all masks set, SPx, 64-bit) and `ev_o` becomes 1.
- R2: The handler address is the vector base of the target level (`vbase1_i`/`vbase2_i`/`vbase3_i`) plus an event-type offset: synchronous 0x000, IRQ 0x080, FIQ 0x100, SError 0x180.
- R3: A further origin offset is added. When the target is the current level it is 0x000 with stack select SP0 and 0x200 with SPx. When the target is a higher level it is 0x400 if the interrupted code ran 64-bit and 0x600 if it ran 32-bit.
- R4: The target level is chosen as follows, and is never level 0. `sync_kind_i` codes are 0 instruction abort, 1 data abort, 2 supervisor call, 3 hypervisor call, 4 secure-monitor call.
  - Aborts and supervisor calls target max(current, 1).
  - Hypervisor calls target max(current, 2).
  - Secure-monitor calls target level 3.
  - Asynchronous events target max(current, 1).
  - Code at level 3 always targets level 3.
- R5: On entry the old processor state is stored in the target level's saved-state register and `ret_addr_i` in its link register. The saved-state and link registers of every other level stay as they were.
- R6: Processor state layout is bit 8 D, 7 A, 6 I, 5 F, 4 illegal-return flag, 3 32-bit flag, 2:1 level, 0 SPx. On entry D, A, I and F are set, the illegal flag and the 32-bit flag are cleared, SPx is set and the level becomes the target.
- R7: In a single cycle the order of acceptance is synchronous, SError, FIQ, IRQ, exception return. Exactly one event is accepted. `ev_o` reports it on the following cycle: 0 none, 1 reset, 2 synchronous, 3 SError, 4 FIQ, 5 IRQ, 6 return.
- R8: An asynchronous request is accepted only while `boundary_i` is high and its mask bit is clear. A masks SError, F masks FIQ and I masks IRQ. Otherwise it leaves pc and state unchanged. Synchronous requests ignore `boundary_i` and the masks.
- R9: A legal return loads `pstate_o` from the current level's saved-state register and `pc_o` from its link register.
- R10: A return is illegal in any of these cases. In each case only the illegal flag is set; level, width and masks stay, and `pc_o` takes the current link register, or stays unchanged at level 0.
  - The saved level is higher than the current level.
  - The saved level equals the current level but the width differs.
  - The 32-bit flag is set with a non-zero saved level.
  - The return is issued at level 0.
- R11: The 32-bit flag changes only when the level changes. It is set only on a return to a lower level and cleared only on entry to a higher level.
- R12: At levels 1 to 3, `save_wr_i` writes `save_st_i`/`save_pc_i` into the current level's saved-state and link registers. At level 0 the write is ignored. In a cycle where an entry targets that same level, the entry's values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also the reset event |
| boundary_i | input | 1 | Current instruction is at a boundary where interrupts may be taken |
| sync_req_i | input | 1 | Synchronous fault or call request |
| sync_kind_i | input | 3 | Kind of synchronous request (codes in R4) |
| serr_req_i | input | 1 | Asynchronous external-abort (SError) request |
| fiq_req_i | input | 1 | Fast interrupt request |
| irq_req_i | input | 1 | Normal interrupt request |
| eret_req_i | input | 1 | Exception-return strobe |
| ret_addr_i | input | AW | Return address saved on entry |
| save_wr_i | input | 1 | Write saved state and link of the current level |
| save_st_i | input | 9 | Saved-state value for the write |
| save_pc_i | input | AW | Link value for the write |
| rst_base_i | input | AW | Reset vector base of level 3 |
| vbase1_i | input | AW | Vector base of level 1 |
| vbase2_i | input | AW | Vector base of level 2 |
| vbase3_i | input | AW | Vector base of level 3 |
| pc_o | output | AW | Next program counter |
| pstate_o | output | 9 | Processor state (layout in R6) |
| ev_o | output | 3 | Event accepted in the previous cycle (codes in R7) |
| saved1_o | output | 9 | Saved-state register of level 1 |
| saved2_o | output | 9 | Saved-state register of level 2 |
| saved3_o | output | 9 | Saved-state register of level 3 |
| link1_o | output | AW | Link register of level 1 |
| link2_o | output | AW | Link register of level 2 |
| link3_o | output | AW | Link register of level 3 |

## Verification
The embedded properties watch several invariants on every cycle:
- one grant at most, and no asynchronous grant off a boundary;
- after any entry, the masks are set, the level is non-zero and not lowered, and the old state appears in the target's saved-state register;
- a return never raises the level, and the width flag never moves while the level stays put.

Exact handler addresses, the target chosen for each request kind, the winner among several simultaneous requests, and which illegal-return cases set the flag are shown only by the bench's scenarios. The same holds for the save-write port being ignored at level 0 and being overridden by an entry.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NLVL = 4;               // privilege levels 0..NLVL-1
    localparam int LW   = $clog2(NLVL);    // level field width
    localparam int OFSW = 11;              // vector offset width (max 0x780)
    localparam int NREQ = 5;               // arbitrated request sources

    typedef enum logic [2:0] {
        SK_IABT = 3'd0,
        SK_DABT = 3'd1,
        SK_SVC  = 3'd2,
        SK_HVC  = 3'd3,
        SK_SMC  = 3'd4
    } sync_kind_t;

    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_RST  = 3'd1,
        EV_SYNC = 3'd2,
        EV_SERR = 3'd3,
        EV_FIQ  = 3'd4,
        EV_IRQ  = 3'd5,
        EV_ERET = 3'd6
    } ev_t;

    typedef enum logic {
        ST_BOOT = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic          d;
        logic          a;
        logic          i;
        logic          f;
        logic          il;
        logic          aa32;
        logic [LW-1:0] el;
        logic          spx;
    } pstate_t;

    localparam int PSW = $bits(pstate_t);

    // event-type offsets
    localparam logic [OFSW-1:0] OFS_SYNC = 11'h000;
    localparam logic [OFSW-1:0] OFS_IRQ  = 11'h080;
    localparam logic [OFSW-1:0] OFS_FIQ  = 11'h100;
    localparam logic [OFSW-1:0] OFS_SERR = 11'h180;
    // origin-group offsets
    localparam logic [OFSW-1:0] GRP_CUR_SP0 = 11'h000;
    localparam logic [OFSW-1:0] GRP_CUR_SPX = 11'h200;
    localparam logic [OFSW-1:0] GRP_LOW_64  = 11'h400;
    localparam logic [OFSW-1:0] GRP_LOW_32  = 11'h600;

    localparam pstate_t PS_BOOT = '{d: 1'b1, a: 1'b1, i: 1'b1, f: 1'b1,
                                    il: 1'b0, aa32: 1'b0,
                                    el: LW'(NLVL - 1), spx: 1'b1};
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            boundary_i,
    input  logic            sync_i,
    input  logic            serr_i,
    input  logic            fiq_i,
    input  logic            irq_i,
    input  logic            eret_i,
    input  logic            mask_a_i,
    input  logic            mask_f_i,
    input  logic            mask_i_i,
    output logic [NREQ-1:0] grant_o,
    output ev_t             ev_o
);
    // index order equals priority: 0 highest
    logic [NREQ-1:0] req;

    always_comb begin
        req[0] = sync_i;
        req[1] = serr_i & boundary_i & ~mask_a_i;
        req[2] = fiq_i  & boundary_i & ~mask_f_i;
        req[3] = irq_i  & boundary_i & ~mask_i_i;
        req[4] = eret_i;
    end

    for (genvar k = 0; k < NREQ; k++) begin : g_pri
        if (k == 0) begin : g_top
            assign grant_o[k] = req[k];
        end else begin : g_low
            assign grant_o[k] = req[k] & ~(|req[k-1:0]);
        end
    end

    always_comb begin
        unique case (1'b1)
            grant_o[0]: ev_o = EV_SYNC;
            grant_o[1]: ev_o = EV_SERR;
            grant_o[2]: ev_o = EV_FIQ;
            grant_o[3]: ev_o = EV_IRQ;
            grant_o[4]: ev_o = EV_ERET;
            default:    ev_o = EV_NONE;
        endcase
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R7
    AST_ASYNC_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |-> !(grant_o[1] | grant_o[2] | grant_o[3])); // R8
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_pkg::*;
#(
    parameter int AW = 64
) (
    input  ev_t           ev_i,
    input  sync_kind_t    kind_i,
    input  logic [LW-1:0] cur_el_i,
    input  logic          cur_spx_i,
    input  logic          cur_aa32_i,
    input  logic [AW-1:0] vbase1_i,
    input  logic [AW-1:0] vbase2_i,
    input  logic [AW-1:0] vbase3_i,
    output logic [LW-1:0] tgt_el_o,
    output logic [AW-1:0] vec_o
);
    logic [LW-1:0]   floor_el;
    logic [OFSW-1:0] type_ofs;
    logic [OFSW-1:0] grp_ofs;
    logic [AW-1:0]   base;

    always_comb begin
        floor_el = LW'(1);
        if (ev_i == EV_SYNC) begin
            unique case (kind_i)
                SK_HVC:  floor_el = LW'(2);
                SK_SMC:  floor_el = LW'(NLVL - 1);
                default: floor_el = LW'(1);
            endcase
        end
        tgt_el_o = (cur_el_i > floor_el) ? cur_el_i : floor_el;
    end

    always_comb begin
        unique case (ev_i)
            EV_IRQ:  type_ofs = OFS_IRQ;
            EV_FIQ:  type_ofs = OFS_FIQ;
            EV_SERR: type_ofs = OFS_SERR;
            default: type_ofs = OFS_SYNC;
        endcase
        if (tgt_el_o == cur_el_i)
            grp_ofs = cur_spx_i ? GRP_CUR_SPX : GRP_CUR_SP0;
        else
            grp_ofs = cur_aa32_i ? GRP_LOW_32 : GRP_LOW_64;
    end

    always_comb begin
        unique case (tgt_el_o)
            LW'(2):  base = vbase2_i;
            LW'(3):  base = vbase3_i;
            default: base = vbase1_i;
        endcase
        vec_o = base + AW'(type_ofs | grp_ofs);
    end
endmodule

// File: rtl/exc_eret_chk.sv
module exc_eret_chk
    import exc_pkg::*;
(
    input  logic [LW-1:0] cur_el_i,
    input  logic          cur_aa32_i,
    input  logic [LW-1:0] sav_el_i,
    input  logic          sav_aa32_i,
    output logic          legal_o
);
    logic from_el0;
    logic goes_up;
    logic width_flip;
    logic narrow_priv;

    always_comb begin
        from_el0    = (cur_el_i == '0);
        goes_up     = (sav_el_i > cur_el_i);
        width_flip  = (sav_el_i == cur_el_i) && (sav_aa32_i != cur_aa32_i);
        narrow_priv = sav_aa32_i && (sav_el_i != '0);
        legal_o     = !(from_el0 || goes_up || width_flip || narrow_priv);
    end
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
    import exc_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           boundary_i,
    input  logic           sync_req_i,
    input  logic [2:0]     sync_kind_i,
    input  logic           serr_req_i,
    input  logic           fiq_req_i,
    input  logic           irq_req_i,
    input  logic           eret_req_i,
    input  logic [AW-1:0]  ret_addr_i,
    input  logic           save_wr_i,
    input  logic [8:0]     save_st_i,
    input  logic [AW-1:0]  save_pc_i,
    input  logic [AW-1:0]  rst_base_i,
    input  logic [AW-1:0]  vbase1_i,
    input  logic [AW-1:0]  vbase2_i,
    input  logic [AW-1:0]  vbase3_i,
    output logic [AW-1:0]  pc_o,
    output logic [8:0]     pstate_o,
    output logic [2:0]     ev_o,
    output logic [8:0]     saved1_o,
    output logic [8:0]     saved2_o,
    output logic [8:0]     saved3_o,
    output logic [AW-1:0]  link1_o,
    output logic [AW-1:0]  link2_o,
    output logic [AW-1:0]  link3_o
);
    ctl_state_t    state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    pstate_t       pst_q, pst_d;
    ev_t           ev_q, ev_d;

    ev_t             ev_sel;
    logic [NREQ-1:0] grant;
    logic [LW-1:0]   tgt_el;
    logic [AW-1:0]   vec;
    logic            ret_legal;
    logic            entry;
    logic            save_ok;
    pstate_t         sav_cur;
    logic [AW-1:0]   lnk_cur;

    pstate_t       sav_w [NLVL];
    logic [AW-1:0] lnk_w [NLVL];

    exc_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary_i (boundary_i),
        .sync_i     (sync_req_i),
        .serr_i     (serr_req_i),
        .fiq_i      (fiq_req_i),
        .irq_i      (irq_req_i),
        .eret_i     (eret_req_i),
        .mask_a_i   (pst_q.a),
        .mask_f_i   (pst_q.f),
        .mask_i_i   (pst_q.i),
        .grant_o    (grant),
        .ev_o       (ev_sel)
    );

    exc_target #(.AW(AW)) u_tgt (
        .ev_i       (ev_sel),
        .kind_i     (sync_kind_t'(sync_kind_i)),
        .cur_el_i   (pst_q.el),
        .cur_spx_i  (pst_q.spx),
        .cur_aa32_i (pst_q.aa32),
        .vbase1_i   (vbase1_i),
        .vbase2_i   (vbase2_i),
        .vbase3_i   (vbase3_i),
        .tgt_el_o   (tgt_el),
        .vec_o      (vec)
    );

    assign sav_cur = sav_w[pst_q.el];
    assign lnk_cur = lnk_w[pst_q.el];

    exc_eret_chk u_ret (
        .cur_el_i   (pst_q.el),
        .cur_aa32_i (pst_q.aa32),
        .sav_el_i   (sav_cur.el),
        .sav_aa32_i (sav_cur.aa32),
        .legal_o    (ret_legal)
    );

    assign entry = (state_q == ST_RUN) &&
                   (ev_sel inside {EV_SYNC, EV_SERR, EV_FIQ, EV_IRQ});
    assign save_ok = (state_q == ST_RUN) && save_wr_i;

    // level 0 has no saved registers
    assign sav_w[0] = '0;
    assign lnk_w[0] = '0;

    for (genvar k = 1; k < NLVL; k++) begin : g_lvl
        pstate_t       sav_r;
        logic [AW-1:0] lnk_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sav_r <= '0;
                lnk_r <= '0;
            end else if (entry && tgt_el == LW'(k)) begin
                sav_r <= pst_q;
                lnk_r <= ret_addr_i;
            end else if (save_ok && pst_q.el == LW'(k)) begin
                sav_r <= pstate_t'(save_st_i);
                lnk_r <= save_pc_i;
            end
        end
        assign sav_w[k] = sav_r;
        assign lnk_w[k] = lnk_r;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            pc_q    <= '0;
            pst_q   <= PS_BOOT;
            ev_q    <= EV_NONE;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            pst_q   <= pst_d;
            ev_q    <= ev_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        pst_d   = pst_q;
        ev_d    = EV_NONE;
        unique case (state_q)
            ST_BOOT: begin
                state_d = ST_RUN;
                pc_d    = rst_base_i;
                pst_d   = PS_BOOT;
                ev_d    = EV_RST;
            end
            ST_RUN: begin
                unique case (ev_sel)
                    EV_SYNC, EV_SERR, EV_FIQ, EV_IRQ: begin
                        pc_d       = vec;
                        pst_d.d    = 1'b1;
                        pst_d.a    = 1'b1;
                        pst_d.i    = 1'b1;
                        pst_d.f    = 1'b1;
                        pst_d.il   = 1'b0;
                        pst_d.aa32 = 1'b0;
                        pst_d.el   = tgt_el;
                        pst_d.spx  = 1'b1;
                        ev_d       = ev_sel;
                    end
                    EV_ERET: begin
                        ev_d = EV_ERET;
                        if (ret_legal) begin
                            pst_d = sav_cur;
                            pc_d  = lnk_cur;
                        end else begin
                            pst_d.il = 1'b1;
                            if (pst_q.el != '0) pc_d = lnk_cur;
                        end
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    assign pc_o     = pc_q;
    assign pstate_o = pst_q;
    assign ev_o     = ev_q;
    assign saved1_o = sav_w[1];
    assign saved2_o = sav_w[2];
    assign saved3_o = sav_w[3];
    assign link1_o  = lnk_w[1];
    assign link2_o  = lnk_w[2];
    assign link3_o  = lnk_w[3];

    AST_BOOT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |=> (ev_q == EV_RST && pst_q.el == LW'(NLVL - 1) && pc_q == $past(rst_base_i))); // R1
    AST_ENTRY_NOT_EL0: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (pst_q.el != '0 && pst_q.el >= $past(pst_q.el))); // R4
    AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (sav_w[pst_q.el] == $past(pst_q) && lnk_w[pst_q.el] == $past(ret_addr_i))); // R5
    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        entry |=> (pst_q.d && pst_q.a && pst_q.i && pst_q.f && pst_q.spx && !pst_q.aa32 && !pst_q.il)); // R6
    AST_RET_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && ev_sel == EV_ERET) |=> (pst_q.el <= $past(pst_q.el))); // R10
    AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pst_q.el == $past(pst_q.el)) |-> (pst_q.aa32 == $past(pst_q.aa32))); // R11
    AST_NARROW_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pst_q.aa32) |-> (pst_q.el < $past(pst_q.el))); // R11
endmodule

// File: tb/tb_exc_vector_ctrl.sv
module tb_exc_vector_ctrl;
    import exc_pkg::*;

    localparam int AW = 64;
    localparam logic [AW-1:0] RST_BASE = 64'h1000_0000;
    localparam logic [AW-1:0] START_PC = 64'h4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boundary_i = 1'b0, sync_req_i = 1'b0, serr_req_i = 1'b0;
    logic fiq_req_i = 1'b0, irq_req_i = 1'b0, eret_req_i = 1'b0, save_wr_i = 1'b0;
    logic [2:0] sync_kind_i = '0;
    logic [8:0] save_st_i = '0;
    logic [AW-1:0] ret_addr_i = '0, save_pc_i = '0;
    logic [AW-1:0] pc_o, link1_o, link2_o, link3_o;
    logic [8:0] pstate_o, saved1_o, saved2_o, saved3_o;
    logic [2:0] ev_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exc_vector_ctrl #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
        .sync_req_i(sync_req_i), .sync_kind_i(sync_kind_i),
        .serr_req_i(serr_req_i), .fiq_req_i(fiq_req_i), .irq_req_i(irq_req_i),
        .eret_req_i(eret_req_i), .ret_addr_i(ret_addr_i),
        .save_wr_i(save_wr_i), .save_st_i(save_st_i), .save_pc_i(save_pc_i),
        .rst_base_i(RST_BASE), .vbase1_i(64'h1_0000), .vbase2_i(64'h2_0000),
        .vbase3_i(64'h3_0000), .pc_o(pc_o), .pstate_o(pstate_o), .ev_o(ev_o),
        .saved1_o(saved1_o), .saved2_o(saved2_o), .saved3_o(saved3_o),
        .link1_o(link1_o), .link2_o(link2_o), .link3_o(link3_o)
    );

    typedef struct packed {
        logic [8:0]  st;
        logic        sreq;
        logic [2:0]  kind;
        logic        serr, fiq, irq, eret, bnd;
        logic [2:0]  ev;
        logic [31:0] pc;
        logic [1:0]  el;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{9'h000, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h10400, 2'd1},
        '{9'h008, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h10600, 2'd1},
        '{9'h002, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h10000, 2'd1},
        '{9'h003, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h10200, 2'd1},
        '{9'h000, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h20400, 2'd2},
        '{9'h003, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h30400, 2'd3},
        '{9'h007, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h30200, 2'd3},
        '{9'h000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd5, 32'h10480, 2'd1},
        '{9'h000, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4, 32'h10500, 2'd1},
        '{9'h000, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 32'h10580, 2'd1},
        '{9'h000, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4, 32'h10500, 2'd1},
        '{9'h000, 1'b1, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 32'h10400, 2'd1},
        '{9'h000, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd3, 32'h10580, 2'd1},
        '{9'h000, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 32'h04000, 2'd0},
        '{9'h043, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 32'h04000, 2'd1},
        '{9'h043, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4, 32'h10300, 2'd1},
        '{9'h1E3, 1'b0, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 32'h04000, 2'd1},
        '{9'h005, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h20200, 2'd2},
        '{9'h003, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd5, 32'h10280, 2'd1},
        '{9'h000, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 32'h10400, 2'd1},
        '{9'h008, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 32'h30600, 2'd3}
    };

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] saved_of(input logic [1:0] el);
        case (el)
            2'd1:    return saved1_o;
            2'd2:    return saved2_o;
            default: return saved3_o;
        endcase
    endfunction

    function automatic logic [AW-1:0] link_of(input logic [1:0] el);
        case (el)
            2'd1:    return link1_o;
            2'd2:    return link2_o;
            default: return link3_o;
        endcase
    endfunction

    task automatic clear_inputs();
        boundary_i = 0; sync_req_i = 0; sync_kind_i = '0; serr_req_i = 0;
        fiq_req_i = 0; irq_req_i = 0; eret_req_i = 0; save_wr_i = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // reset, boot at level 3, then return into the given start state at START_PC
    task automatic start_in(input logic [8:0] st);
        @(negedge clk);
        clear_inputs();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        save_wr_i = 1'b1; save_st_i = st; save_pc_i = START_PC;
        step();
        save_wr_i = 1'b0; eret_req_i = 1'b1;
        step();
        eret_req_i = 1'b0;
    endtask

    task automatic write_save(input logic [8:0] st, input logic [AW-1:0] pc);
        save_wr_i = 1'b1; save_st_i = st; save_pc_i = pc;
        step();
        save_wr_i = 1'b0;
    endtask

    task automatic do_eret();
        eret_req_i = 1'b1;
        step();
        eret_req_i = 1'b0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, then reset wins over other pending requests
        sync_req_i = 1'b1; irq_req_i = 1'b1; boundary_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", pc_o, '0);
        chk("R1 ev in reset", AW'(ev_o), 64'd0);
        rst_n = 1'b1;
        step();
        chk("R1 boot pc", pc_o, RST_BASE);
        chk("R1 boot pstate", AW'(pstate_o), 64'h1E7);
        chk("R1 boot ev", AW'(ev_o), 64'd1);
        clear_inputs();

        // table walk: R2 R3 R4 R5 R6 R7 R8
        for (int n = 0; n < NV; n++) begin
            start_in(TBL[n].st);
            sync_req_i = TBL[n].sreq; sync_kind_i = TBL[n].kind;
            serr_req_i = TBL[n].serr; fiq_req_i = TBL[n].fiq;
            irq_req_i = TBL[n].irq; eret_req_i = TBL[n].eret;
            boundary_i = TBL[n].bnd; ret_addr_i = 64'h8000 + AW'(n);
            step();
            clear_inputs();
            chk($sformatf("R7 ev row %0d", n), AW'(ev_o), AW'(TBL[n].ev));
            chk($sformatf("R2 R3 pc row %0d", n), pc_o, AW'(TBL[n].pc));
            chk($sformatf("R4 level row %0d", n), AW'(pstate_o[2:1]), AW'(TBL[n].el));
            if (TBL[n].ev == 3'd0) begin
                chk($sformatf("R8 state kept row %0d", n), AW'(pstate_o), AW'(TBL[n].st));
            end else begin
                chk($sformatf("R6 new state row %0d", n), AW'(pstate_o),
                    AW'({4'hF, 1'b0, 1'b0, TBL[n].el, 1'b1}));
                chk($sformatf("R5 saved row %0d", n), AW'(saved_of(TBL[n].el)), AW'(TBL[n].st));
                chk($sformatf("R5 link row %0d", n), link_of(TBL[n].el), 64'h8000 + AW'(n));
            end
        end

        // R10: return naming a higher level; R12 write at level 1
        start_in(9'h003);
        write_save(9'h005, 64'h5000);
        chk("R12 saved1 write", AW'(saved1_o), 64'h005);
        chk("R12 link1 write", link1_o, 64'h5000);
        do_eret();
        chk("R10 up pstate", AW'(pstate_o), 64'h013);
        chk("R10 up pc", pc_o, 64'h5000);
        chk("R7 ret ev", AW'(ev_o), 64'd6);
        // R5 R6: entry saves il and clears it
        sync_req_i = 1'b1; sync_kind_i = 3'd2; ret_addr_i = 64'h9100;
        step();
        clear_inputs();
        chk("R6 il cleared", AW'(pstate_o), 64'h1E3);
        chk("R5 il saved", AW'(saved1_o), 64'h013);

        // R10: same level, width change
        start_in(9'h003);
        write_save(9'h00B, 64'h5100);
        do_eret();
        chk("R10 same-level width pstate", AW'(pstate_o), 64'h013);
        chk("R10 same-level width pc", pc_o, 64'h5100);

        // R10: 32-bit to a non-zero level
        start_in(9'h005);
        write_save(9'h00B, 64'h5200);
        do_eret();
        chk("R10 narrow priv pstate", AW'(pstate_o), 64'h015);
        chk("R10 narrow priv pc", pc_o, 64'h5200);

        // R9 R11: legal return to level 0 in 32-bit, then entry back to 64-bit
        start_in(9'h003);
        write_save(9'h008, 64'h6000);
        do_eret();
        chk("R9 legal pstate", AW'(pstate_o), 64'h008);
        chk("R9 legal pc", pc_o, 64'h6000);
        sync_req_i = 1'b1; sync_kind_i = 3'd1; ret_addr_i = 64'h6004;
        step();
        clear_inputs();
        chk("R11 widen on entry pstate", AW'(pstate_o), 64'h1E3);
        chk("R11 widen on entry pc", pc_o, 64'h10600);
        chk("R11 saved narrow", AW'(saved1_o), 64'h008);

        // R10: return at level 0
        start_in(9'h000);
        do_eret();
        chk("R10 el0 pstate", AW'(pstate_o), 64'h010);
        chk("R10 el0 pc", pc_o, START_PC);

        // R12: save write ignored at level 0
        start_in(9'h000);
        write_save(9'h1FF, 64'hDEAD);
        chk("R12 el0 saved1", AW'(saved1_o), 64'h0);
        chk("R12 el0 saved2", AW'(saved2_o), 64'h0);
        chk("R12 el0 saved3", AW'(saved3_o), 64'h0);
        chk("R12 el0 link1", link1_o, 64'h0);
        chk("R12 el0 link3", link3_o, START_PC);
        chk("R12 el0 pstate", AW'(pstate_o), 64'h0);

        // R12 R5: entry to the same level wins over a save write
        start_in(9'h003);
        save_wr_i = 1'b1; save_st_i = 9'h0AA; save_pc_i = 64'h7777;
        sync_req_i = 1'b1; sync_kind_i = 3'd2; ret_addr_i = 64'h9000;
        step();
        clear_inputs();
        chk("R12 entry wins saved1", AW'(saved1_o), 64'h003);
        chk("R12 entry wins link1", link1_o, 64'h9000);
        chk("R5 other level kept", AW'(saved3_o), 64'h003);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule